// File: doc/BRIEF.md
# Key-Locked Register Front End for a Performance Monitor

This block is the memory-mapped front end of a performance-monitor component. It occupies a 4 KB window and takes single-cycle 32-bit word reads and writes on a plain valid/write/address/data bus. It owns a small set of local words: a lock key word, a lock status word, a pair of claim-tag words, and two constant identification words (device type and authentication status). Any other offset is handed downstream through a write port.

Out of reset the block is locked. While it is locked, every write except one to the key word is dropped. A dropped write finishes on the bus without an error, and the block raises a one-cycle `write_dropped` pulse on the following cycle. Writing the unlock key to the key word opens the block. Writing any other value to that word locks it again. Reads never depend on the lock. The claim tags behave differently on each side: the set word always reads back the mask of supported bits, and only the clear word returns the live tag values.

Top module: `pmon_lock_front`

## Requirements
- R1: After a synchronous active-low reset the block is locked, all claim bits are 0 and `write_dropped` is 0.
- R2: A write of exactly 0xC5ACCE55 to the key word at byte offset 0xFB0 unlocks the block. A write of any other value to 0xFB0 locks it. Such a write is accepted whether the block is locked or not.
- R3: While locked, a write to any offset other than 0xFB0 changes no state and is not forwarded. `write_dropped` is 1 for exactly the one cycle after that write.
- R4: A read of the lock status word at 0xFB4 returns bit0=1, bit1=lock state (1 = locked), bit2=0 and all higher bits 0. The values are therefore 0x3 when locked and 0x1 when unlocked.
- R5: A read of the claim-set word at 0xFA0 always returns 0xFF. An accepted write there sets every claim bit whose data bit [7:0] is 1.
- R6: A read of the claim-clear word at 0xFA4 returns the 8 claim bits in [7:0], with the upper bits 0. An accepted write there clears every claim bit whose data bit [7:0] is 1.
- R7: A read of the device-type word at 0xFCC returns 0x16: class 0x6 in [3:0] and sub-type 0x1 in [7:4].
- R8: A read of the authentication word at 0xFB8 returns bit7=1, bit6=`sec_nonintr_dbg` and all other bits 0.
- R9: An accepted write to any non-local offset appears in the same cycle on `fwd_valid`/`fwd_addr`/`fwd_wdata`. Reads of the key word and of any unmapped offset return 0. Address bits [1:0] are ignored when decoding.
- R10: Reads return the same value whether the block is locked or not. Reads and accepted writes never raise `write_dropped`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Byte offset within the window |
| acc_wdata | input | 32 | Write data |
| sec_nonintr_dbg | input | 1 | Value shown in bit 6 of the authentication word |
| acc_rdata | output | 32 | Read data, valid in the access cycle, 0 when not reading |
| fwd_valid | output | 1 | Accepted write to a non-local offset |
| fwd_addr | output | 12 | Forwarded byte offset |
| fwd_wdata | output | 32 | Forwarded write data |
| write_dropped | output | 1 | One-cycle pulse after a write blocked by the lock |

## Verification
The assertions assume that an access lasts exactly one cycle with `acc_valid` high, and that `acc_write` and `acc_wdata` are stable during that cycle. The bench drives each access for a single cycle on the falling edge and leaves at least one idle cycle between accesses. This keeps the pulse that follows a dropped write apart from the next access. The expected values come from a table whose entries assume the lock and claim state left behind by the entries before them. Directed tests then cover reset in the middle of a run, the authentication input, and aliasing of the low address bits.

// File: rtl/pmon_lock_pkg.sv
// Shared constants and the local-word decode for the lock-gated front end.
// Assumes word-aligned 4 KB window; offsets are word indices (byte offset / 4).
package pmon_lock_pkg;
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int CLAIM_W  = 8;
    localparam int WORD_W   = ADDR_W - 2;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'hC5AC_CE55;

    localparam logic [WORD_W-1:0] W_CLAIM_SET = 10'h3E8;  // 0xFA0
    localparam logic [WORD_W-1:0] W_CLAIM_CLR = 10'h3E9;  // 0xFA4
    localparam logic [WORD_W-1:0] W_LOCK_KEY  = 10'h3EC;  // 0xFB0
    localparam logic [WORD_W-1:0] W_LOCK_STAT = 10'h3ED;  // 0xFB4
    localparam logic [WORD_W-1:0] W_AUTH      = 10'h3EE;  // 0xFB8
    localparam logic [WORD_W-1:0] W_DEVTYPE   = 10'h3F3;  // 0xFCC

    localparam logic [3:0] DEV_CLASS   = 4'h6;
    localparam logic [3:0] DEV_SUBTYPE = 4'h1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CLAIM_SET,
        SEL_CLAIM_CLR,
        SEL_LOCK_KEY,
        SEL_LOCK_STAT,
        SEL_AUTH,
        SEL_DEVTYPE
    } word_sel_e;
endpackage

// File: rtl/pmon_addr_decode.sv
// Maps a byte offset onto one of the local words, or SEL_NONE for anything
// handled downstream. Assumes bits [1:0] carry no meaning (word accesses only).
module pmon_addr_decode
    import pmon_lock_pkg::*;
(
    input  logic [WORD_W-1:0] word_idx,
    output word_sel_e         sel
);
    // Purpose: pure compare of the word index against the local map.
    always_comb begin
        unique case (word_idx)
            W_CLAIM_SET: sel = SEL_CLAIM_SET;
            W_CLAIM_CLR: sel = SEL_CLAIM_CLR;
            W_LOCK_KEY:  sel = SEL_LOCK_KEY;
            W_LOCK_STAT: sel = SEL_LOCK_STAT;
            W_AUTH:      sel = SEL_AUTH;
            W_DEVTYPE:   sel = SEL_DEVTYPE;
            default:     sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/pmon_lock_ctrl.sv
// Holds the software lock. Engaged from reset; a key-word write opens it only
// with the exact key, any other value closes it. Assumes key_wr is already
// qualified as a valid write to the key word (the lock never gates that word).
module pmon_lock_ctrl
    import pmon_lock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    output logic              locked
);
    // Purpose: lock state register, updated only by key-word writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      locked <= 1'b1;
        else if (key_wr) locked <= (key_data != UNLOCK_KEY);
    end

    // R2: the exact key opens the lock on the next cycle
    a_r2_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_data == UNLOCK_KEY) |=> !locked);
    // R2: any other key value closes it
    a_r2_bad_key_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_data != UNLOCK_KEY) |=> locked);
    // R3: without a key write the lock state never moves
    a_r3_lock_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr |=> $stable(locked));
endmodule

// File: rtl/pmon_claim_tags.sv
// Eight claim bits with separate set and clear strobes (write-one semantics).
// Assumes set_en and clr_en are already gated by the lock and never both high.
module pmon_claim_tags
    import pmon_lock_pkg::*;
#(
    parameter int NBITS = CLAIM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [NBITS-1:0] mask,
    output logic [NBITS-1:0] tags
);
    // Purpose: per-bit set/clear of the claim register.
    always_ff @(posedge clk) begin
        if (!rst_n)      tags <= '0;
        else if (set_en) tags <= tags | mask;
        else if (clr_en) tags <= tags & ~mask;
    end

    // R3: no accepted strobe, no change
    a_r3_tags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en || clr_en) |=> $stable(tags));
    // R5: every masked bit is set afterwards
    a_r5_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((tags & $past(mask)) == $past(mask)));
    // R6: every masked bit is clear afterwards, unmasked bits kept
    a_r6_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((tags & $past(mask)) == '0 &&
                    (tags & ~$past(mask)) == ($past(tags) & ~$past(mask))));
endmodule

// File: rtl/pmon_read_mux.sv
// Builds read data for the local words; zero for the key word, for any
// downstream offset and when no read is in progress. Independent of the lock
// except for the status bit that reports it.
module pmon_read_mux
    import pmon_lock_pkg::*;
(
    input  logic               rd_en,
    input  word_sel_e          sel,
    input  logic               locked,
    input  logic [CLAIM_W-1:0] tags,
    input  logic               sec_nonintr_dbg,
    output logic [DATA_W-1:0]  rdata
);
    // Purpose: select the read word for the decoded local register.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_CLAIM_SET: rdata[CLAIM_W-1:0] = '1;
                SEL_CLAIM_CLR: rdata[CLAIM_W-1:0] = tags;
                SEL_LOCK_STAT: rdata[2:0] = {1'b0, locked, 1'b1};
                SEL_AUTH:      rdata[7:0] = {1'b1, sec_nonintr_dbg, 6'b0};
                SEL_DEVTYPE:   rdata[7:0] = {DEV_SUBTYPE, DEV_CLASS};
                default:       rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pmon_lock_front.sv
// Top of the lock-gated register front end. Decodes single-cycle word
// accesses, applies the software lock to every write but the key word,
// serves the local words and forwards accepted downstream writes.
// Assumes each access is one cycle of acc_valid.
module pmon_lock_front
    import pmon_lock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              sec_nonintr_dbg,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              fwd_valid,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [DATA_W-1:0] fwd_wdata,
    output logic              write_dropped
);
    word_sel_e          sel;
    logic               locked;
    logic [CLAIM_W-1:0] tags;
    logic               wr_any;
    logic               wr_ok;
    logic               wr_blocked;

    pmon_addr_decode u_dec (
        .word_idx (acc_addr[ADDR_W-1:2]),
        .sel      (sel)
    );

    // Purpose: classify the current write against the lock.
    always_comb begin
        wr_any     = acc_valid && acc_write;
        wr_ok      = wr_any && (!locked || sel == SEL_LOCK_KEY);
        wr_blocked = wr_any && locked && sel != SEL_LOCK_KEY;
    end

    pmon_lock_ctrl u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (wr_any && sel == SEL_LOCK_KEY),
        .key_data (acc_wdata),
        .locked   (locked)
    );

    pmon_claim_tags #(.NBITS(CLAIM_W)) u_claim (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (wr_ok && sel == SEL_CLAIM_SET),
        .clr_en (wr_ok && sel == SEL_CLAIM_CLR),
        .mask   (acc_wdata[CLAIM_W-1:0]),
        .tags   (tags)
    );

    pmon_read_mux u_rd (
        .rd_en           (acc_valid && !acc_write),
        .sel             (sel),
        .locked          (locked),
        .tags            (tags),
        .sec_nonintr_dbg (sec_nonintr_dbg),
        .rdata           (acc_rdata)
    );

    // Purpose: pass accepted writes for non-local offsets downstream.
    always_comb begin
        fwd_valid = wr_ok && sel == SEL_NONE;
        fwd_addr  = acc_addr;
        fwd_wdata = acc_wdata;
    end

    // Purpose: one-cycle notice that the lock swallowed a write.
    always_ff @(posedge clk) begin
        if (!rst_n) write_dropped <= 1'b0;
        else        write_dropped <= wr_blocked;
    end

    // R3: nothing leaves the block while it is locked
    a_r3_no_fwd_locked: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> !locked);
    // R10: a read never produces a dropped-write pulse
    a_r10_read_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> !write_dropped);
    // R3: dropped pulse only follows a write made while locked
    a_r3_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid || !acc_write) |=> !write_dropped);
endmodule

// File: tb/pmon_lock_front_tb.sv
module pmon_lock_front_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 21;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic        exp_fwd;
        logic        exp_drop;
        logic [3:0]  req;
    } vec_t;

    // Sequential table: each entry assumes the state left by the ones above.
    localparam vec_t TBL [NVEC] = '{
        '{1'b0, 12'hFB4, 32'h0,         32'h3,  1'b0, 1'b0, 4'd4},  // R4 locked status
        '{1'b1, 12'hFA0, 32'h0F,        32'h0,  1'b0, 1'b1, 4'd3},  // R3 claim set blocked
        '{1'b0, 12'hFA4, 32'h0,         32'h0,  1'b0, 1'b0, 4'd3},  // R3 tags unchanged
        '{1'b1, 12'h010, 32'h1234,      32'h0,  1'b0, 1'b1, 4'd3},  // R3 no forward
        '{1'b0, 12'hFCC, 32'h0,         32'h16, 1'b0, 1'b0, 4'd7},  // R7 device type
        '{1'b0, 12'hFB8, 32'h0,         32'h80, 1'b0, 1'b0, 4'd8},  // R8 auth, input low
        '{1'b0, 12'hFA0, 32'h0,         32'hFF, 1'b0, 1'b0, 4'd5},  // R5 set word mask
        '{1'b1, 12'hFB0, 32'h12345678,  32'h0,  1'b0, 1'b0, 4'd2},  // R2 wrong key
        '{1'b0, 12'hFB4, 32'h0,         32'h3,  1'b0, 1'b0, 4'd2},  // R2 still locked
        '{1'b1, 12'hFB0, 32'hC5ACCE55,  32'h0,  1'b0, 1'b0, 4'd2},  // R2 key
        '{1'b0, 12'hFB4, 32'h0,         32'h1,  1'b0, 1'b0, 4'd2},  // R2 unlocked
        '{1'b1, 12'hFA0, 32'hFFFF_FFA5, 32'h0,  1'b0, 1'b0, 4'd5},  // R5 set bits
        '{1'b0, 12'hFA4, 32'h0,         32'hA5, 1'b0, 1'b0, 4'd5},  // R5 tags visible
        '{1'b1, 12'hFA4, 32'h81,        32'h0,  1'b0, 1'b0, 4'd6},  // R6 clear bits
        '{1'b0, 12'hFA4, 32'h0,         32'h24, 1'b0, 1'b0, 4'd6},  // R6 remaining
        '{1'b1, 12'h010, 32'hDEADBEEF,  32'h0,  1'b1, 1'b0, 4'd9},  // R9 forward
        '{1'b0, 12'hFB0, 32'h0,         32'h0,  1'b0, 1'b0, 4'd9},  // R9 key reads 0
        '{1'b0, 12'h100, 32'h0,         32'h0,  1'b0, 1'b0, 4'd9},  // R9 unmapped 0
        '{1'b1, 12'hFB0, 32'h0,         32'h0,  1'b0, 1'b0, 4'd2},  // R2 relock
        '{1'b0, 12'hFA4, 32'h0,         32'h24, 1'b0, 1'b0, 4'd10}, // R10 read unaffected
        '{1'b0, 12'hFB4, 32'h0,         32'h3,  1'b0, 1'b0, 4'd2}   // R2 locked again
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic        sec_nonintr_dbg = 1'b0;
    logic [31:0] acc_rdata;
    logic        fwd_valid;
    logic [11:0] fwd_addr;
    logic [31:0] fwd_wdata;
    logic        write_dropped;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    pmon_lock_front u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .sec_nonintr_dbg(sec_nonintr_dbg),
        .acc_rdata(acc_rdata), .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
        .fwd_wdata(fwd_wdata), .write_dropped(write_dropped)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act %0d cycles exp < 20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act 0x%0h exp 0x%0h", tag, act, exp);
        end
    endtask

    // One access for one cycle; comb outputs sampled mid-cycle, pulse one cycle later.
    task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d,
                          input logic [31:0] exp_rd, input logic exp_fwd,
                          input logic exp_drop, input string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d;
        #1;
        if (!wr) check({tag, " rdata"}, acc_rdata, exp_rd);
        check({tag, " fwd_valid"}, {31'b0, fwd_valid}, {31'b0, exp_fwd});
        if (exp_fwd) begin
            check({tag, " fwd_addr"}, {20'b0, fwd_addr}, {20'b0, a});
            check({tag, " fwd_wdata"}, fwd_wdata, d);
        end
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        check({tag, " write_dropped"}, {31'b0, write_dropped}, {31'b0, exp_drop});
        @(negedge clk);
        check({tag, " pulse length"}, {31'b0, write_dropped}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 dropped after reset", {31'b0, write_dropped}, 32'h0);
        access(1'b0, 12'hFB4, 32'h0, 32'h3, 1'b0, 1'b0, "R1 locked out of reset");
        access(1'b0, 12'hFA4, 32'h0, 32'h0, 1'b0, 1'b0, "R1 claims clear");

        for (int i = 0; i < NVEC; i++) begin
            access(TBL[i].wr, TBL[i].addr, TBL[i].wdata, TBL[i].exp_rd,
                   TBL[i].exp_fwd, TBL[i].exp_drop, $sformatf("R%0d vec%0d", TBL[i].req, i));
        end

        // R8: authentication bit 6 follows the input
        sec_nonintr_dbg = 1'b1;
        access(1'b0, 12'hFB8, 32'h0, 32'hC0, 1'b0, 1'b0, "R8 auth input high");
        sec_nonintr_dbg = 1'b0;
        // R9: low address bits ignored
        access(1'b0, 12'hFB7, 32'h0, 32'h3, 1'b0, 1'b0, "R9 aliased status");
        // R10: unlocked reads match locked reads, accepted write no pulse
        access(1'b1, 12'hFB0, 32'hC5ACCE55, 32'h0, 1'b0, 1'b0, "R10 unlock no pulse");
        access(1'b0, 12'hFA4, 32'h0, 32'h24, 1'b0, 1'b0, "R10 tags unlocked");
        access(1'b0, 12'hFCC, 32'h0, 32'h16, 1'b0, 1'b0, "R10 devtype unlocked");
        // R1: reset in mid-run relocks and clears claims
        access(1'b1, 12'hFA0, 32'hFF, 32'h0, 1'b0, 1'b0, "R5 set all");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        access(1'b0, 12'hFB4, 32'h0, 32'h3, 1'b0, 1'b0, "R1 relocked by reset");
        access(1'b0, 12'hFA4, 32'h0, 32'h0, 1'b0, 1'b0, "R1 claims cleared by reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule